// File: doc/BRIEF.md
# Wake-up edge latch controller

The controller watches thirteen external wake-up lines. Each line is resynchronised to the local clock, and its transitions are compared against an edge polarity that software picks for that line. A matching transition sets a sticky pending bit for the line. Software reads the pending bits through a status register, which shows only the lines that are enabled. It drops a pending bit by writing a one to its position in a clear register. A single registered wake request stays high while any enabled line has a pending event.

Line i maps to register bit i. Bits 0 to 11 carry the twelve lines of the first input group, and bit 12 carries line 0 of the second group. The pending bits have no meaningful value after reset. The model loads them with a parameter pattern, all ones by default, so software must clear them before it enables a line.

Registers are word-aligned byte offsets on a simple request/acknowledge bus. Offset 0x0 holds the polarity bits, 0x4 the enable bits, 0x8 the clear bits and 0xC the status bits.

Top module: `wake_edge_ctrl`

## Requirements
- R1: Each line passes through a two-flop synchronizer. A transition on line i sets pending bit i only when it matches polarity bit i at offset 0x0, where 1 selects rising and 0 selects falling. A transition of the other polarity leaves the bit unchanged. The polarity register resets to 0.
- R2: The enable register at offset 0x4 has one bit per line, where 1 means enabled, and resets to 0. Bits 31:13 read 0, and writing ones to them has no effect.
- R3: Writing 1 to bit i at offset 0x8 clears pending bit i, and writing 0 leaves it unchanged. Offset 0x8 always reads 0.
- R4: Offset 0xC reads pending AND enable, bit by bit. It is read-only, and writes to it change nothing. A line that is disabled still records events, and they become visible once the line is enabled.
- R5: After reset, the pending bits hold the parameter PEND_POWERUP, which is all ones by default. Enabling lines without clearing them first exposes that pattern.
- R6: wake_req is registered. It equals the OR of the status bits from the previous clock cycle, so it rises one cycle after status becomes nonzero.
- R7: When a clear write and a detected event hit the same bit in the same cycle, the event wins and the bit stays pending.
- R8: bus_ack pulses one cycle after a sampled bus_req, and bus_rdata holds the read value during that cycle. An address that is not word-aligned reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_pins | input | 13 | Asynchronous wake-up lines |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access completed |
| wake_req | output | 1 | Registered combined wake request |

## Verification
The hardest case to reach is R7, where a clear write and a detected edge land on the same bit in one cycle. The edge reaches the pending logic only after two synchronizer stages, so the bench changes a line on a falling clock edge and waits two rising edges. It then presents the clear write so that the write is sampled on the exact edge where the event is live. A second clear, issued one cycle later, confirms that the bit can still be cleared. The power-up pattern of R5 is exposed by enabling lines before any clear is written.

// File: rtl/wake_pkg.sv
package wake_pkg;
  // word index of each register (byte offset >> 2)
  typedef enum logic [1:0] {
    REG_EDGE = 2'd0,
    REG_EN   = 2'd1,
    REG_CLR  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int unsigned N_IN   = 13,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] pins,
  input  logic [N_IN-1:0] rise_sel,
  output logic [N_IN-1:0] evt
);
  for (genvar i = 0; i < N_IN; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              cur;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], pins[i]};
        prev  <= chain[STAGES-1];
      end
    end
    assign cur    = chain[STAGES-1];
    assign evt[i] = rise_sel[i] ? (cur & ~prev) : (~cur & prev);
  end
endmodule

// File: rtl/wake_pend.sv
module wake_pend #(
  parameter int unsigned    N_IN         = 13,
  parameter logic [N_IN-1:0] PEND_POWERUP = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] evt,
  input  logic [N_IN-1:0] clr,
  output logic [N_IN-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= PEND_POWERUP;
    else     pend <= (pend & ~clr) | evt;
  end

  // R7: an event seen in a cycle is pending in the next, clear or not
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ((pend & $past(evt)) == $past(evt)));
  // R3: a clear without a concurrent event empties the bit
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ((pend & $past(clr & ~evt)) == '0));
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int unsigned N_IN   = 13,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_IN-1:0]   status,
  output logic [N_IN-1:0]   edge_sel,
  output logic [N_IN-1:0]   enable,
  output logic [N_IN-1:0]   clr_mask,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);
  logic     hit;
  reg_sel_e sel;
  logic     wr_en;
  logic [DATA_W-1:0] rd_mux;

  assign hit   = (addr[1:0] == 2'b00) && ((addr >> 4) == '0);
  assign sel   = reg_sel_e'(addr[3:2]);
  assign wr_en = req && wr && hit;

  assign clr_mask = (wr_en && sel == REG_CLR) ? wdata[N_IN-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (sel)
        REG_EDGE: rd_mux[N_IN-1:0] = edge_sel;
        REG_EN:   rd_mux[N_IN-1:0] = enable;
        REG_CLR:  rd_mux           = '0;
        REG_STAT: rd_mux[N_IN-1:0] = status;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_sel <= '0;
      enable   <= '0;
      rdata    <= '0;
      ack      <= 1'b0;
    end else begin
      ack   <= req;
      rdata <= (req && !wr) ? rd_mux : '0;
      if (wr_en && sel == REG_EDGE) edge_sel <= wdata[N_IN-1:0];
      if (wr_en && sel == REG_EN)   enable   <= wdata[N_IN-1:0];
    end
  end

  // R8: every request is acknowledged on the next cycle
  a_r8_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> ack);
  // R2: reserved read bits are always zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ack |-> (rdata[DATA_W-1:N_IN] == '0));
endmodule

// File: rtl/wake_edge_ctrl.sv
module wake_edge_ctrl #(
  parameter int unsigned     N_IN         = 13,
  parameter int unsigned     DATA_W       = 32,
  parameter int unsigned     ADDR_W       = 4,
  parameter int unsigned     SYNC_STAGES  = 2,
  parameter logic [N_IN-1:0] PEND_POWERUP = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   wake_pins,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              wake_req
);
  logic [N_IN-1:0] edge_sel, enable, clr_mask, evt, pend, status;

  wake_edge_det #(.N_IN(N_IN), .STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst(rst), .pins(wake_pins), .rise_sel(edge_sel), .evt(evt)
  );

  wake_pend #(.N_IN(N_IN), .PEND_POWERUP(PEND_POWERUP)) u_pend (
    .clk(clk), .rst(rst), .evt(evt), .clr(clr_mask), .pend(pend)
  );

  wake_regs #(.N_IN(N_IN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .req(bus_req), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .status(status), .edge_sel(edge_sel),
    .enable(enable), .clr_mask(clr_mask), .rdata(bus_rdata), .ack(bus_ack)
  );

  assign status = pend & enable;

  always_ff @(posedge clk) begin
    if (rst) wake_req <= 1'b0;
    else     wake_req <= |status;
  end

  // R6: wake request tracks last cycle's status
  a_r6_wake_registered: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (wake_req == $past(|status)));
endmodule

// File: tb/wake_edge_ctrl_test.sv
module wake_edge_ctrl_test;
  localparam int N = 13;
  localparam logic [31:0] ALL = 32'h1FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pins = '0;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_ack, wake_req;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wake_edge_ctrl uut (
    .clk(clk), .rst(rst), .wake_pins(pins), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .wake_req(wake_req)
  );

  // {sel_rising, transition_rising, line[3:0]}
  localparam logic [5:0] VEC [0:7] = '{
    6'b11_0000, 6'b10_0001, 6'b00_0010, 6'b01_0011,
    6'b11_1100, 6'b00_1011, 6'b10_0111, 6'b01_0101
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d, output logic ack);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata; ack = bus_ack;
    bus_req = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic ak;
    wait_cyc(3);
    @(negedge clk) rst = 0;

    // reset state
    check("R6 wake_req after reset", {31'd0, wake_req}, 0);
    bus_read(4'h0, rd, ak); check("R1 polarity reset", rd, 0);
    check("R8 ack on read", {31'd0, ak}, 1);
    bus_read(4'h4, rd, ak); check("R2 enable reset", rd, 0);
    bus_read(4'hC, rd, ak); check("R4 status masked at reset", rd, 0);

    // R5: power-up pattern shows when enabled without clearing; R6 timing
    bus_write(4'h4, 32'h1);
    check("R6 wake not yet", {31'd0, wake_req}, 0);
    @(negedge clk);
    check("R6 wake one cycle later", {31'd0, wake_req}, 1);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'hC, rd, ak); check("R5 power-up pending pattern", rd, ALL);
    bus_read(4'h4, rd, ak); check("R2 reserved enable bits", rd, ALL);

    // R3: zero write no effect, single bit clear, read of clear reg
    bus_write(4'h8, 32'h0);
    bus_read(4'hC, rd, ak); check("R3 zero write keeps pending", rd, ALL);
    bus_write(4'h8, 32'h8);
    bus_read(4'hC, rd, ak); check("R3 clear bit 3", rd, ALL & ~32'h8);
    bus_read(4'h8, rd, ak); check("R3 clear reg reads 0", rd, 0);

    // R4: status write ignored
    bus_write(4'hC, 32'h0);
    bus_read(4'hC, rd, ak); check("R4 status read-only", rd, ALL & ~32'h8);
    // R8: misaligned write ignored, misaligned read 0
    bus_write(4'h5, 32'h0);
    bus_read(4'h4, rd, ak); check("R8 misaligned write ignored", rd, ALL);
    bus_read(4'h5, rd, ak); check("R8 misaligned read zero", rd, 0);

    bus_write(4'h8, ALL);
    bus_read(4'hC, rd, ak); check("R3 clear all", rd, 0);
    @(negedge clk);
    check("R6 wake low after clear", {31'd0, wake_req}, 0);

    // R1 table walk
    for (int v = 0; v < 8; v++) begin
      logic sel, rise;
      logic [3:0] idx;
      logic [31:0] exp;
      {sel, rise, idx} = VEC[v];
      exp = (sel == rise) ? (32'h1 << idx) : 32'h0;
      bus_write(4'h0, sel ? ALL : 32'h0);
      bus_write(4'h4, ALL);
      @(negedge clk) pins[idx] = ~rise;
      wait_cyc(6);
      bus_write(4'h8, ALL);
      @(negedge clk) pins[idx] = rise;
      wait_cyc(6);
      bus_read(4'hC, rd, ak);
      check($sformatf("R1 vector %0d line %0d", v, idx), rd, exp);
      check($sformatf("R6 wake vector %0d", v), {31'd0, wake_req}, {31'd0, exp != 0});
      @(negedge clk) pins[idx] = 1'b0;
      wait_cyc(6);
    end

    // R4: disabled line records, shows when enabled
    bus_write(4'h0, ALL);
    bus_write(4'h8, ALL);
    bus_write(4'h4, 32'h0);
    @(negedge clk) pins[9] = 1'b1;
    wait_cyc(6);
    bus_read(4'hC, rd, ak); check("R4 disabled hidden", rd, 0);
    check("R6 disabled no wake", {31'd0, wake_req}, 0);
    bus_write(4'h4, 32'h200);
    bus_read(4'hC, rd, ak); check("R4 visible after enable", rd, 32'h200);
    @(negedge clk) pins[9] = 1'b0;
    bus_write(4'h4, ALL);
    bus_write(4'h8, ALL);

    // R7: clear and event in the same cycle
    @(negedge clk) pins[4] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = 4'h8; bus_wdata = 32'h10;
    @(posedge clk);
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
    bus_read(4'hC, rd, ak); check("R7 event beats clear", rd, 32'h10);
    bus_write(4'h8, 32'h10);
    bus_read(4'hC, rd, ak); check("R7 later clear works", rd, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule